// File: doc/BRIEF.md
# Per-Timeslot Channel Control Datapath

This block keeps one 8-bit control word and one small signalling value for each timeslot of a framed byte stream. It has 24 timeslots in T1 mode and 32 in E1 mode. Each beat carries one timeslot and has two parts: the byte headed for the line (from the system side) and the byte just received from the line. The block uses the slot's control word to build the two outgoing bytes. Local loopback sends the system byte back toward the system side. Remote loopback sends the line byte back out to the line. In T1 signalling frames the block overwrites the least significant bit of the line-bound byte with a signalling bit, unless the slot is marked as a clear channel.

For each slot, the transmit signalling value comes from one of two sources. It either follows the signalling input that travels with each beat, or it is held at a value written through the register port. When the slot follows the input, its stored value is refreshed from every accepted beat, so software can read back the most recent signalling. Control words and signalling values are written and read through a simple register port. The `mode_e1` pin selects T1 or E1.

Beats enter and leave through valid/ready handshakes and pass through one output register. Back-pressure rules:
- Upstream may present a beat at any time, and a beat is taken on an edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or downstream is ready, so full throughput is sustained while `out_ready` stays high.
- While `out_valid` is high and `out_ready` is low, every output field is held.

Top module: `tslot_ctrl_path`

## Requirements
- R1: During and after reset, `out_valid` is low, and every control word and signalling value reads as zero.
- R2: On a clock edge with `reg_we` high, the register port writes a value; `reg_rdata` is combinational from `reg_addr`. Address decoding:
  - `reg_addr[5]`=0 selects the control word of slot `reg_addr[4:0]`.
  - `reg_addr[5]`=1 selects that slot's signalling value, held in the low SIG_W bits; the upper bits read as zero.
  - In T1 mode (`mode_e1`=0), writes to slots 24..31 are dropped and those addresses read as zero.
- R3: When control bit 4 is set, `out_rx_byte` equals the beat's `in_tx_byte`. Otherwise it equals `in_rx_byte`.
- R4: When control bit 5 is set, `out_tx_byte` equals the beat's `in_rx_byte`. This takes priority over robbed-bit insertion.
- R5: When control bit 1 is set, `out_sig` is the slot's stored signalling value. Otherwise `out_sig` equals `in_sig`, and the stored value is refreshed to `in_sig`. If a beat refresh and a register write hit the same slot's signalling in the same cycle, the refresh wins.
- R6: Robbed-bit insertion happens only when all of these hold: T1 mode, `in_sig_frame`=1, control bit 0 clear, and remote loopback off. It replaces bit 0 of the line-bound byte with `out_sig[in_sig_phase]` and leaves bits 7..1 unchanged. No robbing occurs in E1 mode or with bit 0 set.
- R7: With bits 4 and 5 both set, both loopbacks apply at once, each in its own direction.
- R8: A beat uses the control and signalling values held before its acceptance edge. A write to the same slot in that cycle takes effect from the slot's next beat.
- R9: Each accepted beat appears on the outputs one clock later, with `out_slot` equal to its slot. `in_ready` = !`out_valid` || `out_ready`. Outputs hold while stalled.
- R10: In T1 mode, beats for slots 24..31 pass both bytes through unchanged and carry `out_sig`=`in_sig`, whatever was stored for them in E1 mode.
- R11: Control bits 7, 6, 3 and 2 are stored and read back but change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_e1 | input | 1 | 1 = E1 (32 slots), 0 = T1 (24 slots, robbing allowed) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Bit 5 space select (0 control, 1 signalling), bits 4..0 slot |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may be taken |
| in_slot | input | 5 | Timeslot number of the beat |
| in_tx_byte | input | 8 | System byte bound for the line |
| in_rx_byte | input | 8 | Byte received from the line |
| in_sig | input | SIG_W | Signalling input for this slot |
| in_sig_frame | input | 1 | Beat belongs to a signalling frame |
| in_sig_phase | input | PH_W | Which signalling bit a robbed frame carries |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_slot | output | 5 | Timeslot number of the output beat |
| out_tx_byte | output | 8 | Byte sent to the line |
| out_rx_byte | output | 8 | Byte sent to the system side |
| out_sig | output | SIG_W | Transmit signalling chosen for the slot |

## Verification
Two functions can fall on the same edge: a register-port write and the acceptance of a beat for the same slot. This happens both for a control word and for the signalling value. In the signalling case, the write also collides with the refresh that a beat makes when the slot follows its input.

A directed step writes a local-loopback word to a slot while that slot's beat is presented. It then expects the old behaviour for that beat and the new behaviour for the following beat.

A long random phase issues writes on about a quarter of the cycles, to random addresses, while beats stream with random back-pressure and mode changes. The reference model applies the old-value rule and the refresh-wins rule and compares every output and the read data on every clock.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
  localparam int CTL_W = 8;

  // Control word, bit 7 first
  typedef struct packed {
    logic aux_msg;       // bit 7, stored only
    logic aux_ind;       // bit 6, stored only
    logic loop_remote;   // bit 5, line rx byte -> line tx byte
    logic loop_local;    // bit 4, system tx byte -> system rx byte
    logic tst_tx;        // bit 3, stored only
    logic tst_rx;        // bit 2, stored only
    logic sig_from_reg;  // bit 1, transmit signalling from register
    logic clear_chan;    // bit 0, suppress bit robbing (T1)
  } ctl_word_t;
endpackage

// File: rtl/tsc_ctrl_store.sv
`timescale 1ns/1ps
module tsc_ctrl_store
  import tsc_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int T1N    = 24,
  parameter int SIG_W  = 2,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_e1,
  input  logic              wr_en,
  input  logic              wr_sig_space,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic              rd_sig_space,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [CTL_W-1:0]  rd_data,
  input  logic [SLOT_W-1:0] lk_slot,
  output logic              lk_live,
  output logic              lk_loop_local,
  output logic              lk_loop_remote,
  output logic              lk_sig_from_reg,
  output logic              lk_clear_chan,
  output logic [SIG_W-1:0]  lk_sig,
  input  logic              rf_en,
  input  logic [SLOT_W-1:0] rf_slot,
  input  logic [SIG_W-1:0]  rf_val
);
  ctl_word_t        word_all [NSLOT];
  logic [SIG_W-1:0] sig_all  [NSLOT];
  ctl_word_t        lk_word;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam bit IN_T1 = (g < T1N);
    logic             live;
    ctl_word_t        word_q;
    logic [SIG_W-1:0] sig_q;
    logic             hit_w;
    logic             hit_r;

    assign live  = mode_e1 || IN_T1;
    assign hit_w = wr_en && live && (wr_slot == SLOT_W'(g));
    assign hit_r = rf_en && (rf_slot == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     word_q <= '0;
      else if (hit_w && !wr_sig_space) word_q <= ctl_word_t'(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    sig_q <= '0;
      else if (hit_r)                sig_q <= rf_val;
      else if (hit_w && wr_sig_space) sig_q <= wr_data[SIG_W-1:0];
    end

    assign word_all[g] = live ? word_q : '0;
    assign sig_all[g]  = live ? sig_q  : '0;
  end

  assign rd_data = rd_sig_space ? CTL_W'(sig_all[rd_slot]) : word_all[rd_slot];

  assign lk_word         = word_all[lk_slot];
  assign lk_sig          = sig_all[lk_slot];
  assign lk_live         = mode_e1 || (int'(lk_slot) < T1N);
  assign lk_loop_local   = lk_word.loop_local;
  assign lk_loop_remote  = lk_word.loop_remote;
  assign lk_sig_from_reg = lk_word.sig_from_reg;
  assign lk_clear_chan   = lk_word.clear_chan;
endmodule

// File: rtl/tsc_slot_xform.sv
`timescale 1ns/1ps
module tsc_slot_xform #(
  parameter int BYTE_W = 8,
  parameter int SIG_W  = 2,
  parameter int PH_W   = 1
) (
  input  logic              mode_e1,
  input  logic              live,
  input  logic              loop_local,
  input  logic              loop_remote,
  input  logic              sig_from_reg,
  input  logic              clear_chan,
  input  logic [SIG_W-1:0]  sig_stored,
  input  logic [BYTE_W-1:0] tx_in,
  input  logic [BYTE_W-1:0] rx_in,
  input  logic [SIG_W-1:0]  sig_in,
  input  logic              sig_frame,
  input  logic [PH_W-1:0]   sig_phase,
  output logic [BYTE_W-1:0] tx_out,
  output logic [BYTE_W-1:0] rx_out,
  output logic [SIG_W-1:0]  sig_out,
  output logic              refresh
);
  logic              rob;
  logic [BYTE_W-1:0] robbed;

  assign sig_out = sig_from_reg ? sig_stored : sig_in;
  assign rob     = live && !mode_e1 && sig_frame && !clear_chan;
  assign robbed  = {tx_in[BYTE_W-1:1], sig_out[sig_phase]};

  always_comb begin
    if (loop_remote) tx_out = rx_in;
    else if (rob)    tx_out = robbed;
    else             tx_out = tx_in;
  end

  assign rx_out  = loop_local ? tx_in : rx_in;
  assign refresh = live && !sig_from_reg;
endmodule

// File: rtl/tsc_out_stage.sv
`timescale 1ns/1ps
module tsc_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) d_q <= in_data;
    end
  end

  assign out_valid = v_q;
  assign out_data  = d_q;
endmodule

// File: rtl/tslot_ctrl_path.sv
`timescale 1ns/1ps
module tslot_ctrl_path
  import tsc_pkg::*;
#(
  parameter int T1_SLOTS = 24,
  parameter int E1_SLOTS = 32,
  parameter int BYTE_W   = 8,
  parameter int SIG_W    = 2,
  localparam int SLOT_W  = $clog2(E1_SLOTS),
  localparam int ADDR_W  = SLOT_W + 1,
  localparam int PH_W    = (SIG_W > 1) ? $clog2(SIG_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_e1,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTL_W-1:0]  reg_wdata,
  output logic [CTL_W-1:0]  reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [BYTE_W-1:0] in_tx_byte,
  input  logic [BYTE_W-1:0] in_rx_byte,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic              in_sig_frame,
  input  logic [PH_W-1:0]   in_sig_phase,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SLOT_W-1:0] out_slot,
  output logic [BYTE_W-1:0] out_tx_byte,
  output logic [BYTE_W-1:0] out_rx_byte,
  output logic [SIG_W-1:0]  out_sig
);
  localparam int PW = SLOT_W + 2 * BYTE_W + SIG_W;

  logic              lk_live, lk_loop_local, lk_loop_remote, lk_sig_from_reg, lk_clear_chan;
  logic [SIG_W-1:0]  lk_sig;
  logic [BYTE_W-1:0] x_tx, x_rx;
  logic [SIG_W-1:0]  x_sig;
  logic              x_refresh;
  logic              beat_acc;
  logic [PW-1:0]     pack_in, pack_out;

  assign beat_acc = in_valid && in_ready;

  tsc_ctrl_store #(
    .NSLOT(E1_SLOTS), .T1N(T1_SLOTS), .SIG_W(SIG_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1),
    .wr_en(reg_we), .wr_sig_space(reg_addr[ADDR_W-1]),
    .wr_slot(reg_addr[SLOT_W-1:0]), .wr_data(reg_wdata),
    .rd_sig_space(reg_addr[ADDR_W-1]), .rd_slot(reg_addr[SLOT_W-1:0]),
    .rd_data(reg_rdata),
    .lk_slot(in_slot), .lk_live(lk_live),
    .lk_loop_local(lk_loop_local), .lk_loop_remote(lk_loop_remote),
    .lk_sig_from_reg(lk_sig_from_reg), .lk_clear_chan(lk_clear_chan),
    .lk_sig(lk_sig),
    .rf_en(beat_acc && x_refresh), .rf_slot(in_slot), .rf_val(in_sig)
  );

  tsc_slot_xform #(
    .BYTE_W(BYTE_W), .SIG_W(SIG_W), .PH_W(PH_W)
  ) u_xform (
    .mode_e1(mode_e1), .live(lk_live),
    .loop_local(lk_loop_local), .loop_remote(lk_loop_remote),
    .sig_from_reg(lk_sig_from_reg), .clear_chan(lk_clear_chan),
    .sig_stored(lk_sig),
    .tx_in(in_tx_byte), .rx_in(in_rx_byte), .sig_in(in_sig),
    .sig_frame(in_sig_frame), .sig_phase(in_sig_phase),
    .tx_out(x_tx), .rx_out(x_rx), .sig_out(x_sig), .refresh(x_refresh)
  );

  assign pack_in = {in_slot, x_tx, x_rx, x_sig};

  tsc_out_stage #(.W(PW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pack_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pack_out)
  );

  assign {out_slot, out_tx_byte, out_rx_byte, out_sig} = pack_out;
endmodule

// File: rtl/tslot_ctrl_path_checks.sv
`timescale 1ns/1ps
module tsc_checks #(
  parameter int SLOT_W = 5,
  parameter int BYTE_W = 8,
  parameter int SIG_W  = 2,
  parameter int T1N    = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_e1,
  input logic              in_valid,
  input logic              in_ready,
  input logic [SLOT_W-1:0] in_slot,
  input logic [BYTE_W-1:0] in_tx_byte,
  input logic [BYTE_W-1:0] in_rx_byte,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SLOT_W-1:0] out_slot,
  input logic [BYTE_W-1:0] out_tx_byte,
  input logic [BYTE_W-1:0] out_rx_byte,
  input logic [SIG_W-1:0]  out_sig,
  input logic              lk_loop_local,
  input logic              lk_loop_remote
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R9: stalled output keeps every field
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_slot) && $stable(out_tx_byte)
      && $stable(out_rx_byte) && $stable(out_sig));

  // R9: accepted beat shows up one clock later
  a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid && out_slot == $past(in_slot));

  // R3
  a_r3_local_loop: assert property (@(posedge clk) disable iff (!rst_n)
    acc && lk_loop_local |=> out_rx_byte == $past(in_tx_byte));

  // R4
  a_r4_remote_loop: assert property (@(posedge clk) disable iff (!rst_n)
    acc && lk_loop_remote |=> out_tx_byte == $past(in_rx_byte));

  // R6: E1 never robs
  a_r6_e1_no_rob: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode_e1 && !lk_loop_remote |=> out_tx_byte == $past(in_tx_byte));

  // R10: idle T1 slots pass through
  a_r10_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !mode_e1 && (int'(in_slot) >= T1N)
      |=> out_tx_byte == $past(in_tx_byte) && out_rx_byte == $past(in_rx_byte));
endmodule

bind tslot_ctrl_path tsc_checks #(
  .SLOT_W(SLOT_W), .BYTE_W(BYTE_W), .SIG_W(SIG_W), .T1N(T1_SLOTS)
) u_checks (
  .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1),
  .in_valid(in_valid), .in_ready(in_ready), .in_slot(in_slot),
  .in_tx_byte(in_tx_byte), .in_rx_byte(in_rx_byte),
  .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot),
  .out_tx_byte(out_tx_byte), .out_rx_byte(out_rx_byte), .out_sig(out_sig),
  .lk_loop_local(lk_loop_local), .lk_loop_remote(lk_loop_remote)
);

// File: tb/tslot_ctrl_path_tb.sv
`timescale 1ns/1ps
module tslot_ctrl_path_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_e1 = 1'b1;
  logic       reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_slot = '0;
  logic [7:0] in_tx_byte = '0, in_rx_byte = '0;
  logic [1:0] in_sig = '0;
  logic       in_sig_frame = 1'b0;
  logic       in_sig_phase = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [4:0] out_slot;
  logic [7:0] out_tx_byte, out_rx_byte;
  logic [1:0] out_sig;

  always #4 clk = ~clk;

  tslot_ctrl_path dut_i (.*);

  int    n_chk = 0, n_err = 0, cyc = 0;
  bit    done = 0, stall = 0;
  string focus = "R1";

  // reference model state
  logic [7:0] m_ctrl [32];
  logic [1:0] m_sig  [32];
  bit         m_ov, m_acc;
  logic [4:0] m_slot;
  logic [7:0] m_tx, m_rx;
  logic [1:0] m_so;
  string      m_ttag = "R6", m_rtag = "R3";

  function automatic logic [7:0] m_read(logic [5:0] a);
    bit live = mode_e1 || (a[4:0] < 5'd24);
    if (!live) return 8'h00;
    return a[5] ? {6'b0, m_sig[a[4:0]]} : m_ctrl[a[4:0]];
  endfunction

  always @(posedge clk) begin
    bit live, acc, rob;
    logic [7:0] c;
    logic [1:0] su;
    int s;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_ctrl[i] = '0; m_sig[i] = '0; end
      m_ov = 0; m_acc = 0; m_slot = '0; m_tx = '0; m_rx = '0; m_so = '0;
    end else begin
      s    = int'(in_slot);
      acc  = in_valid && (!m_ov || out_ready);
      live = mode_e1 || (s < 24);
      c    = live ? m_ctrl[s] : 8'h00;
      su   = (live && c[1]) ? m_sig[s] : in_sig;
      if (acc) begin
        rob    = live && !mode_e1 && in_sig_frame && !c[0];
        m_slot = in_slot;
        m_so   = su;
        m_tx   = c[5] ? in_rx_byte : rob ? {in_tx_byte[7:1], su[in_sig_phase]} : in_tx_byte;
        m_rx   = c[4] ? in_tx_byte : in_rx_byte;
        m_ttag = !live ? "R10" : (c[5] && c[4]) ? "R7" : c[5] ? "R4" : "R6";
        m_rtag = !live ? "R10" : (c[5] && c[4]) ? "R7" : c[4] ? "R3" : "R11";
        m_ov   = 1;
      end else if (out_ready) m_ov = 0;
      if (reg_we && (mode_e1 || reg_addr[4:0] < 5'd24)) begin
        if (reg_addr[5]) m_sig[reg_addr[4:0]] = reg_wdata[1:0];
        else             m_ctrl[reg_addr[4:0]] = reg_wdata;
      end
      if (acc && live && !c[1]) m_sig[s] = in_sig;   // refresh wins (R5)
      m_acc = acc;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s [%s]: actual=%0h expected=%0h", req, what, focus, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // compare on every clock, then update background stimulus
  task automatic tick();
    @(negedge clk);
    check("R9", "in_ready", 32'(in_ready), 32'(!m_ov || out_ready));
    check("R9", "out_valid", 32'(out_valid), 32'(m_ov));
    if (m_ov) begin
      check("R9", "out_slot", 32'(out_slot), 32'(m_slot));
      check(m_ttag, "out_tx_byte", 32'(out_tx_byte), 32'(m_tx));
      check(m_rtag, "out_rx_byte", 32'(out_rx_byte), 32'(m_rx));
      check("R5", "out_sig", 32'(out_sig), 32'(m_so));
    end
    check("R2", "reg_rdata", 32'(reg_rdata), 32'(m_read(reg_addr)));
    out_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
    if (!reg_we) reg_addr = 6'($urandom);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic send(logic [4:0] s, logic [7:0] tx, logic [7:0] rx,
                      logic [1:0] sg, logic fr, logic ph);
    in_valid = 1; in_slot = s; in_tx_byte = tx; in_rx_byte = rx;
    in_sig = sg; in_sig_frame = fr; in_sig_phase = ph;
    forever begin
      tick();
      if (m_acc) break;
    end
    in_valid = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] exp, string req);
    reg_addr = a; #1;
    check(req, "readback", 32'(reg_rdata), 32'(exp));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid in reset", 32'(out_valid), 0);
    rd(6'd0, 8'h00, "R1"); rd(6'd17, 8'h00, "R1"); rd(6'd33, 8'h00, "R1"); rd(6'd63, 8'h00, "R1");
    rst_n = 1;
    tick();
    check("R1", "out_valid after reset", 32'(out_valid), 0);

    // E1 setup and directed loops
    focus = "R3 R4 R7 R11"; mode_e1 = 1;
    wr(6'd3, 8'h10); wr(6'd5, 8'h20); wr(6'd7, 8'h30); wr(6'd11, 8'hCC);
    wr(6'd9, 8'h02); wr(6'd41, 8'h02); wr(6'd26, 8'h30);
    rd(6'd11, 8'hCC, "R11"); rd(6'd41, 8'h02, "R2");
    send(5'd3, 8'h11, 8'h22, 2'b00, 1'b0, 1'b0);
    check("R3", "local loop rx", 32'(out_rx_byte), 32'h11);
    check("R3", "local loop tx", 32'(out_tx_byte), 32'h11);
    send(5'd5, 8'h33, 8'h44, 2'b00, 1'b1, 1'b0);
    check("R4", "remote loop tx", 32'(out_tx_byte), 32'h44);
    send(5'd7, 8'h55, 8'h66, 2'b00, 1'b0, 1'b0);
    check("R7", "both loops tx", 32'(out_tx_byte), 32'h66);
    check("R7", "both loops rx", 32'(out_rx_byte), 32'h55);
    send(5'd11, 8'h77, 8'h88, 2'b01, 1'b1, 1'b0);
    check("R11", "aux bits tx", 32'(out_tx_byte), 32'h77);
    check("R11", "aux bits rx", 32'(out_rx_byte), 32'h88);
    focus = "R5";
    send(5'd9, 8'h01, 8'h02, 2'b01, 1'b0, 1'b0);
    check("R5", "register signalling", 32'(out_sig), 32'h2);
    send(5'd12, 8'h03, 8'h04, 2'b11, 1'b0, 1'b0);
    check("R5", "input signalling", 32'(out_sig), 32'h3);
    rd(6'd44, 8'h03, "R5");
    focus = "R6 E1";
    send(5'd12, 8'hF0, 8'h00, 2'b11, 1'b1, 1'b0);
    check("R6", "no robbing in E1", 32'(out_tx_byte), 32'hF0);

    // streaming frames with back-pressure
    focus = "R9 E1 frames"; stall = 1;
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 32; s++)
        send(5'(s), 8'($urandom), 8'($urandom), 2'($urandom), f[0], 1'($urandom));
    stall = 0;

    // T1 robbing
    focus = "R6 T1"; mode_e1 = 0;
    wr(6'd4, 8'h01); wr(6'd6, 8'h21);
    send(5'd2, 8'hF0, 8'h0F, 2'b01, 1'b1, 1'b0);
    check("R6", "robbed lsb phase0", 32'(out_tx_byte), 32'hF1);
    send(5'd2, 8'hF1, 8'h0F, 2'b01, 1'b1, 1'b1);
    check("R6", "robbed lsb phase1", 32'(out_tx_byte), 32'hF0);
    send(5'd2, 8'hF0, 8'h0F, 2'b01, 1'b0, 1'b0);
    check("R6", "non-signalling frame", 32'(out_tx_byte), 32'hF0);
    send(5'd4, 8'hF0, 8'h0F, 2'b01, 1'b1, 1'b0);
    check("R6", "clear channel", 32'(out_tx_byte), 32'hF0);
    send(5'd6, 8'hF0, 8'h0E, 2'b01, 1'b1, 1'b0);
    check("R4", "remote loop over robbing", 32'(out_tx_byte), 32'h0E);
    send(5'd9, 8'hE0, 8'h00, 2'b01, 1'b1, 1'b1);
    check("R6", "robbed bit from register sig", 32'(out_tx_byte), 32'hE1);

    // R10 and T1 drop of out-of-range writes
    focus = "R10";
    send(5'd26, 8'hAB, 8'hCD, 2'b10, 1'b1, 1'b0);
    check("R10", "idle slot tx", 32'(out_tx_byte), 32'hAB);
    check("R10", "idle slot rx", 32'(out_rx_byte), 32'hCD);
    check("R10", "idle slot sig", 32'(out_sig), 32'h2);
    rd(6'd26, 8'h00, "R2");
    wr(6'd27, 8'h10);
    mode_e1 = 1;
    rd(6'd27, 8'h00, "R2");
    rd(6'd26, 8'h30, "R2");
    mode_e1 = 0;

    // R8: write and beat to the same slot on the same edge
    focus = "R8";
    repeat (2) tick();
    reg_we = 1; reg_addr = 6'd1; reg_wdata = 8'h10;
    send(5'd1, 8'hA5, 8'h3C, 2'b00, 1'b0, 1'b0);
    reg_we = 0;
    check("R8", "beat uses old word", 32'(out_rx_byte), 32'h3C);
    send(5'd1, 8'h5A, 8'hC3, 2'b00, 1'b0, 1'b0);
    check("R8", "next beat uses new word", 32'(out_rx_byte), 32'h5A);

    // random phase: writes, modes, stalls, beats all mixed
    focus = "R8 R5 random"; stall = 1;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        reg_we = 1; reg_addr = 6'($urandom); reg_wdata = 8'($urandom);
      end
      if ($urandom_range(0, 199) == 0) mode_e1 = ~mode_e1;
      send(5'($urandom), 8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
      reg_we = 0;
      if ($urandom_range(0, 7) == 0) tick();
    end
    stall = 0;
    repeat (4) tick();
    summary();
  end
endmodule